// File: doc/BRIEF.md
# Card Command Framer with CRC-4

This block assembles the command words a contactless reader sends to a small memory card when it reads or writes one byte. It also checks the CRC that comes back with each read byte. The card family comes in three sizes. A one-byte type code, loaded once after the card has been set up, fixes the address width and the number of bytes. Every later command is then sized to match.

A read command is the address with a read flag below it. A write command is the address, a write flag, the data byte and a 4-bit checksum. The checksum is worked out one bit per clock, least significant bit first, over the data byte placed above the command bits. The block reports the finished word together with its length in bits.

A 12-bit read response is split into a data byte and a check nibble. The nibble is compared with a checksum computed over the read command and the returned byte, and a mismatch is flagged. Commands and responses use separate checksum engines, so both can be in flight at the same time.

Top module: `card_cmd_framer`

## Requirements
- R1: Loading type 0x0D selects a 5-bit address and 22 bytes, 0x1D selects 8 bits and 256 bytes, and 0x3D selects 10 bits and 1024 bytes. After any of these three, `card_ok` is 1 and `card_unknown` is 0.
- R2: Any other type code sets `card_unknown`=1 and `card_ok`=0. While no known card is loaded, every command request is refused, and responses are dropped so that `rsp_done` never pulses.
- R3: An accepted read of address A gives `cmd_word` = (A<<1)|1 and `cmd_len` = address bits + 1, with `cmd_done` high in the cycle after the accepting edge.
- R4: An accepted write has bit 0 = 0, the address in bits L:1 (L = address bits), the data byte starting at bit L+1 and the CRC nibble starting at bit L+9. It gives `cmd_len` = L+13 and raises `cmd_done` L+10 cycles after the accepting edge.
- R5: The CRC starts at 0x5. It takes message bits least significant first; for each bit, feedback = crc[0] XOR bit, crc = crc>>1, and crc is XORed with 0xC when feedback is 1. No final XOR is applied. The message is (data << (L+1)) | command, over L+9 bits.
- R6: A write to an address of 4 or below is refused.
- R7: A read or write to an address at or beyond the card size is refused. A refusal is a `cmd_done` pulse with `cmd_refused`=1, `cmd_word`=0 and `cmd_len`=0, in the cycle after the accepting edge.
- R8: While a write is being processed, `cmd_busy` is 1 and further requests are ignored; they produce no `cmd_done`.
- R9: A response frame puts data in bits 7:0 and the check nibble in bits 11:8, paired with the address that was read. L+10 cycles later, `rsp_done` pulses with `rsp_data` set to the byte and `rsp_crc_err` set to 1 exactly when the nibble differs from the R5 CRC of the read command and that byte.
- R10: A write request and a response check accepted on the same edge run independently, and each gives the result it would give alone.
- R11: After reset, `card_ok`, `card_unknown`, `cmd_busy`, `cmd_done` and `rsp_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load a card type code |
| cfg_type | input | 8 | Card type code |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 8 | Byte to write |
| rsp_valid | input | 1 | Response frame present |
| rsp_addr | input | ADDR_W | Address the response belongs to |
| rsp_frame | input | 12 | Received response frame |
| card_ok | output | 1 | A known card type is loaded |
| card_unknown | output | 1 | Last loaded code was not recognised |
| cmd_busy | output | 1 | Write checksum in progress |
| cmd_done | output | 1 | Command result strobe |
| cmd_refused | output | 1 | Request was refused |
| cmd_word | output | ADDR_W+13 | Command bits, bit 0 sent first |
| cmd_len | output | LEN_W | Number of valid bits in `cmd_word` |
| rsp_done | output | 1 | Response check strobe |
| rsp_data | output | 8 | Data byte from the response |
| rsp_crc_err | output | 1 | Check nibble mismatch |

## Verification
A write command and a response check can complete in the same cycle, because both take L+10 cycles when they start together on a card of one size. The bench starts both on one edge, records the cycle in which each strobe rises, and requires the two cycles to match. It also compares each result with its own model value, computed as if that operation had run alone. Random runs repeat this overlap, with and without a corrupted check nibble.

// File: rtl/cmdfr_pkg.sv
package cmdfr_pkg;
  localparam int SZ_W = 11;
  localparam int LOCKED_TOP = 4;

  typedef struct packed {
    logic            ok;
    logic [3:0]      alen;
    logic [SZ_W-1:0] size;
  } geom_t;

  function automatic geom_t geom_of(input logic [7:0] code);
    geom_t g;
    case (code)
      8'h0D:   g = '{ok: 1'b1, alen: 4'd5,  size: 11'd22};
      8'h1D:   g = '{ok: 1'b1, alen: 4'd8,  size: 11'd256};
      8'h3D:   g = '{ok: 1'b1, alen: 4'd10, size: 11'd1024};
      default: g = '{ok: 1'b0, alen: 4'd0,  size: 11'd0};
    endcase
    return g;
  endfunction
endpackage

// File: rtl/card_geom.sv
module card_geom
  import cmdfr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [7:0]      code,
  output logic            ok,
  output logic            unknown,
  output logic [3:0]      alen,
  output logic [SZ_W-1:0] size
);
  geom_t nxt;
  assign nxt = geom_of(code);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok      <= 1'b0;
      unknown <= 1'b0;
      alen    <= '0;
      size    <= '0;
    end else if (load) begin
      ok      <= nxt.ok;
      unknown <= !nxt.ok;
      alen    <= nxt.alen;
      size    <= nxt.size;
    end
  end
endmodule

// File: rtl/crc4_serial.sv
module crc4_serial #(
  parameter int MSG_W = 19,
  parameter int LEN_W = 5,
  parameter logic [3:0] POLY = 4'hC,
  parameter logic [3:0] INIT = 4'h5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [MSG_W-1:0] msg,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic [3:0]       crc
);
  logic [MSG_W-1:0] sh;
  logic [LEN_W-1:0] cnt;
  logic             fb;
  logic [3:0]       step;

  assign fb   = crc[0] ^ sh[0];
  assign step = {1'b0, crc[3:1]} ^ (fb ? POLY : 4'h0);
  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      cnt  <= '0;
      crc  <= INIT;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        sh  <= msg;
        cnt <= len;
        crc <= INIT;
      end else if (busy) begin
        crc <= step;
        sh  <= sh >> 1;
        cnt <= cnt - 1'b1;
        if (cnt == LEN_W'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/card_cmd_framer.sv
module card_cmd_framer
  import cmdfr_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int MSG_W  = ADDR_W + 9,
  localparam int WORD_W = ADDR_W + 13,
  localparam int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [7:0]        cfg_type,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [11:0]       rsp_frame,
  output logic              card_ok,
  output logic              card_unknown,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic              cmd_refused,
  output logic [WORD_W-1:0] cmd_word,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              rsp_done,
  output logic [7:0]        rsp_data,
  output logic              rsp_crc_err
);
  logic [3:0]      g_alen;
  logic [SZ_W-1:0] g_size;

  card_geom u_geom (
    .clk(clk), .rst(rst), .load(cfg_load), .code(cfg_type),
    .ok(card_ok), .unknown(card_unknown), .alen(g_alen), .size(g_size)
  );

  // shared geometry-derived shifts
  logic [LEN_W-1:0] data_sh, msg_len;
  assign data_sh = LEN_W'(g_alen) + LEN_W'(1);
  assign msg_len = LEN_W'(g_alen) + LEN_W'(9);

  // command path
  logic             take, refuse, wr_start;
  logic [MSG_W-1:0] wr_msg_in, w_msg;
  logic [3:0]       w_alen, wr_crc;
  logic             wr_busy, wr_done;

  assign take   = req_valid && !cmd_busy;
  assign refuse = !card_ok
               || (32'(req_addr) >= 32'(g_size))
               || (req_write && 32'(req_addr) <= LOCKED_TOP);
  assign wr_start  = take && !refuse && req_write;
  assign wr_msg_in = (MSG_W'(req_data) << data_sh) | MSG_W'({req_addr, 1'b0});

  crc4_serial #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_wr_crc (
    .clk(clk), .rst(rst), .start(wr_start), .msg(wr_msg_in), .len(msg_len),
    .busy(wr_busy), .done(wr_done), .crc(wr_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_busy    <= 1'b0;
      cmd_done    <= 1'b0;
      cmd_refused <= 1'b0;
      cmd_word    <= '0;
      cmd_len     <= '0;
      w_msg       <= '0;
      w_alen      <= '0;
    end else begin
      cmd_done <= 1'b0;
      if (cmd_busy) begin
        if (wr_done) begin
          cmd_busy    <= 1'b0;
          cmd_done    <= 1'b1;
          cmd_refused <= 1'b0;
          cmd_word    <= WORD_W'(w_msg)
                       | (WORD_W'(wr_crc) << (LEN_W'(w_alen) + LEN_W'(9)));
          cmd_len     <= LEN_W'(w_alen) + LEN_W'(13);
        end
      end else if (take) begin
        if (refuse) begin
          cmd_done    <= 1'b1;
          cmd_refused <= 1'b1;
          cmd_word    <= '0;
          cmd_len     <= '0;
        end else if (req_write) begin
          cmd_busy <= 1'b1;
          w_msg    <= wr_msg_in;
          w_alen   <= g_alen;
        end else begin
          cmd_done    <= 1'b1;
          cmd_refused <= 1'b0;
          cmd_word    <= WORD_W'({req_addr, 1'b1});
          cmd_len     <= data_sh;
        end
      end
    end
  end

  // response path
  logic             rd_start, rd_busy, rd_done;
  logic [MSG_W-1:0] rd_msg_in;
  logic [3:0]       rd_crc, rd_exp;
  logic [7:0]       rd_byte;

  assign rd_start  = rsp_valid && card_ok && !rd_busy;
  assign rd_msg_in = (MSG_W'(rsp_frame[7:0]) << data_sh) | MSG_W'({rsp_addr, 1'b1});

  crc4_serial #(.MSG_W(MSG_W), .LEN_W(LEN_W)) u_rd_crc (
    .clk(clk), .rst(rst), .start(rd_start), .msg(rd_msg_in), .len(msg_len),
    .busy(rd_busy), .done(rd_done), .crc(rd_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_exp      <= '0;
      rd_byte     <= '0;
      rsp_done    <= 1'b0;
      rsp_data    <= '0;
      rsp_crc_err <= 1'b0;
    end else begin
      rsp_done <= rd_done;
      if (rd_start) begin
        rd_exp  <= rsp_frame[11:8];
        rd_byte <= rsp_frame[7:0];
      end
      if (rd_done) begin
        rsp_data    <= rd_byte;
        rsp_crc_err <= (rd_crc != rd_exp);
      end
    end
  end
endmodule

// File: rtl/card_cmd_framer_checker.sv
module card_cmd_framer_checker #(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W + 13,
  localparam int LEN_W  = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              card_ok,
  input logic              card_unknown,
  input logic              cmd_busy,
  input logic              cmd_done,
  input logic              cmd_refused,
  input logic [WORD_W-1:0] cmd_word,
  input logic [LEN_W-1:0]  cmd_len
);
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({card_ok, card_unknown}));

  a_r2_no_card_refuses: assert property (@(posedge clk) disable iff (rst)
    (!card_ok && req_valid && !cmd_busy) |=> (cmd_done && cmd_refused));

  a_r3_read_flag: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !cmd_refused && cmd_len <= LEN_W'(11)) |-> cmd_word[0]);

  a_r4_write_flag: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && !cmd_refused && cmd_len > LEN_W'(11)) |-> !cmd_word[0]);

  a_r7_refused_empty: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && cmd_refused) |-> (cmd_len == '0 && cmd_word == '0));

  a_r8_busy_no_done: assert property (@(posedge clk) disable iff (rst)
    cmd_busy |-> !cmd_done);
endmodule

bind card_cmd_framer card_cmd_framer_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .card_ok(card_ok),
  .card_unknown(card_unknown), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
  .cmd_refused(cmd_refused), .cmd_word(cmd_word), .cmd_len(cmd_len)
);

// File: tb/card_cmd_framer_test.sv
module card_cmd_framer_test;
  localparam int ADDR_W = 10;
  localparam int WORD_W = ADDR_W + 13;
  localparam int LEN_W  = $clog2(WORD_W + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_load = 0; logic [7:0] cfg_type = 0;
  logic req_valid = 0, req_write = 0;
  logic [ADDR_W-1:0] req_addr = 0, rsp_addr = 0;
  logic [7:0] req_data = 0;
  logic rsp_valid = 0; logic [11:0] rsp_frame = 0;
  logic card_ok, card_unknown, cmd_busy, cmd_done, cmd_refused;
  logic [WORD_W-1:0] cmd_word; logic [LEN_W-1:0] cmd_len;
  logic rsp_done, rsp_crc_err; logic [7:0] rsp_data;

  int n_chk = 0, n_bad = 0;
  int cur_alen = 0, cur_size = 0;

  always #10 clk = ~clk;

  card_cmd_framer #(.ADDR_W(ADDR_W)) uut (.*);

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] crc4(logic [31:0] m, int n);
    logic [3:0] s = 4'h5; logic fb;
    for (int i = 0; i < n; i++) begin
      fb = s[0] ^ m[i];
      s = {1'b0, s[3:1]} ^ (fb ? 4'hC : 4'h0);
    end
    return s;
  endfunction

  task automatic load(logic [7:0] code);
    @(negedge clk); cfg_load = 1; cfg_type = code;
    @(negedge clk); cfg_load = 0;
    case (code)
      8'h0D: begin cur_alen = 5;  cur_size = 22;   end
      8'h1D: begin cur_alen = 8;  cur_size = 256;  end
      8'h3D: begin cur_alen = 10; cur_size = 1024; end
      default: begin cur_alen = 0; cur_size = 0; end
    endcase
    chk("R1 card_ok", card_ok, cur_size != 0);
    chk("R2 card_unknown", card_unknown, cur_size == 0);
  endtask

  task automatic do_cmd(bit wr, int addr, logic [7:0] d);
    int k = 0; logic [31:0] msg; bit refd;
    refd = (cur_size == 0) || addr >= cur_size || (wr && addr <= 4);
    @(negedge clk); req_valid = 1; req_write = wr; req_addr = addr[ADDR_W-1:0]; req_data = d;
    @(negedge clk); req_valid = 0;
    while (!cmd_done && k < 60) begin @(negedge clk); k++; end
    chk("R7 cmd_done seen", cmd_done, 1);
    chk(refd ? "R6/R7 refused" : "R3 not refused", cmd_refused, refd);
    if (refd) begin
      chk("R7 refuse latency", k, 0);
      chk("R7 refused word", cmd_word, 0);
    end else if (!wr) begin
      chk("R3 read word", cmd_word, (addr << 1) | 1);
      chk("R3 read len", cmd_len, cur_alen + 1);
      chk("R3 read latency", k, 0);
    end else begin
      msg = (32'(d) << (cur_alen + 1)) | (addr << 1);
      chk("R4 R5 write word", cmd_word,
          msg | (32'(crc4(msg, cur_alen + 9)) << (cur_alen + 9)));
      chk("R4 write len", cmd_len, cur_alen + 13);
      chk("R4 write latency", k, cur_alen + 10);
    end
  endtask

  task automatic do_rsp(int addr, logic [7:0] d, bit bad);
    int k = 0; logic [3:0] c;
    c = crc4((32'(d) << (cur_alen + 1)) | (addr << 1) | 1, cur_alen + 9);
    @(negedge clk); rsp_valid = 1; rsp_addr = addr[ADDR_W-1:0];
    rsp_frame = {c ^ (bad ? 4'h9 : 4'h0), d};
    @(negedge clk); rsp_valid = 0;
    while (!rsp_done && k < 60) begin @(negedge clk); k++; end
    chk("R9 rsp latency", k, cur_alen + 10);
    chk("R9 rsp data", rsp_data, d);
    chk("R9 rsp crc err", rsp_crc_err, bad);
  endtask

  task automatic overlap(int waddr, logic [7:0] wd, int raddr, logic [7:0] rd, bit bad);
    int k = 0, kc = -1, kr = -1; logic [31:0] msg; logic [3:0] c;
    msg = (32'(wd) << (cur_alen + 1)) | (waddr << 1);
    c = crc4((32'(rd) << (cur_alen + 1)) | (raddr << 1) | 1, cur_alen + 9);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = waddr[ADDR_W-1:0]; req_data = wd;
    rsp_valid = 1; rsp_addr = raddr[ADDR_W-1:0]; rsp_frame = {c ^ (bad ? 4'h3 : 4'h0), rd};
    @(negedge clk); req_valid = 0; rsp_valid = 0;
    while ((kc < 0 || kr < 0) && k < 60) begin
      if (cmd_done && kc < 0) begin
        kc = k;
        chk("R10 write word", cmd_word,
            msg | (32'(crc4(msg, cur_alen + 9)) << (cur_alen + 9)));
      end
      if (rsp_done && kr < 0) begin
        kr = k;
        chk("R10 rsp err", rsp_crc_err, bad);
        chk("R10 rsp data", rsp_data, rd);
      end
      @(negedge clk); k++;
    end
    chk("R10 same cycle", kc, kr);
    chk("R10 latency", kc, cur_alen + 10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dones, a;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 card_ok", card_ok, 0);
    chk("R11 card_unknown", card_unknown, 0);
    chk("R11 busy", cmd_busy, 0);
    chk("R11 cmd_done", cmd_done, 0);
    chk("R11 rsp_done", rsp_done, 0);

    do_cmd(0, 10, 8'h00);
    @(negedge clk); rsp_valid = 1; @(negedge clk); rsp_valid = 0;
    dones = 0;
    repeat (30) begin @(negedge clk); dones += rsp_done; end
    chk("R2 rsp dropped", dones, 0);
    load(8'h2D);
    do_cmd(1, 8, 8'hA5);

    load(8'h0D);
    do_cmd(0, 21, 8'h00);
    do_cmd(0, 22, 8'h00);
    do_cmd(1, 4, 8'h5A);
    do_cmd(1, 5, 8'h5A);
    do_cmd(1, 22, 8'h11);
    do_rsp(3, 8'h3C, 0);
    do_rsp(3, 8'h3C, 1);
    load(8'h1D);
    do_cmd(0, 255, 8'h00);
    do_cmd(0, 256, 8'h00);
    do_cmd(1, 255, 8'hFF);
    load(8'h3D);
    do_cmd(0, 1023, 8'h00);
    do_cmd(1, 1023, 8'h80);
    do_rsp(1000, 8'h01, 0);

    // R8: request during busy write is ignored
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = 100; req_data = 8'h42;
    @(negedge clk); req_write = 0; req_addr = 7;
    chk("R8 busy", cmd_busy, 1);
    @(negedge clk); req_valid = 0;
    dones = 0;
    repeat (40) begin @(negedge clk); dones += cmd_done; end
    chk("R8 single done", dones, 1);
    chk("R8 last is write", cmd_word[0], 0);

    overlap(9, 8'h77, 40, 8'h12, 0);
    overlap(500, 8'h00, 3, 8'hFE, 1);

    for (int i = 0; i < 120; i++) begin
      case ($urandom % 3)
        0: load(8'h0D);
        1: load(8'h1D);
        default: load(8'h3D);
      endcase
      a = $urandom % (cur_size + 8);
      case ($urandom % 3)
        0: do_cmd(0, a, 8'h00);
        1: do_cmd(1, a, 8'($urandom));
        default: overlap(5 + $urandom % (cur_size - 5), 8'($urandom),
                         $urandom % cur_size, 8'($urandom), 1'($urandom));
      endcase
      do_rsp($urandom % cur_size, 8'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule